// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port behind a small synchronous register bus. Every pin has its own direction, digital-enable and alternate-function routing bits, and its own interrupt detector. The detector senses a rising edge, a falling edge, either edge, a high level or a low level. It has a per-pin enable mask, readable raw and masked status, and a write-one-to-clear register for latched edges.

The data register has no single address. It occupies a whole window, and the word address inside that window is a per-pin mask. A write changes only the pins whose mask bit is set, so software can flip one pin with a single store and no read-modify-write. A read returns zero for every unselected pin. Pad signals are modelled as an output value and an output enable per pin. A pin that is routed to its alternate function takes both signals from the alternate source instead.

The bus accepts a transfer in every cycle it is selected and never stalls. It has no back-pressure. Writes take effect at the sampling edge, and read data is combinational in the same cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every configuration register (direction, sense, both-edges, polarity, interrupt mask, alternate select, digital enable) and the data register are 0. Every pad output enable is 0 and `irq` is 0.
- R2: Byte addresses 0x000–0x3FC form the data window. Control registers sit at 0x400 + 4·k with k = 0 direction, 1 sense type (1 = level), 2 both-edges, 3 polarity (1 = rising/high), 4 interrupt mask, 5 raw status (read-only), 6 masked status (read-only), 7 clear (write-only, reads 0), 8 alternate select, 9 digital enable. Any address with bit 11 set reads 0, and writes to it have no effect.
- R3: A data read returns 0 on every pin n for which address bit n+2 is 0.
- R4: A data write updates data bit n only where address bit n+2 is 1. All other bits keep their value.
- R5: When a pin's alternate-select and digital-enable bits are both 1, its pad value and enable come from `alt_out`/`alt_oe`. Otherwise the pad value is the data bit and the enable is the direction bit.
- R6: A pin whose digital-enable bit is 0 reads as 0 in the data window. Its raw interrupt status stays 0.
- R7: For an edge-sensed pin, a detected edge sets the raw status bit, and the bit holds until a 1 is written to that bit of the clear register. If an edge and a clear land in the same cycle, the bit stays set.
- R8: For a level-sensed pin, raw status follows the synchronized pin level: high when polarity is 1, low when polarity is 0. Writing to the clear register has no effect on it.
- R9: For an edge-sensed pin, both-edges = 1 detects either edge. Otherwise polarity 1 detects rising edges only and polarity 0 detects falling edges only.
- R10: Masked status equals raw status AND interrupt mask. `irq` is high exactly when any masked status bit is 1.
- R11: Writes on consecutive cycles each update the pad value at the following clock edge, so an output pin can change once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Transfer in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| irq | output | 1 | Port interrupt |

## Verification
The collision that matters is a software clear of a latched edge in the same cycle that a new edge on that pin is detected. The bench provokes it by counting the two synchronizer stages and the edge register from the pad change, then placing the clear-register write so that it is sampled at exactly the edge that latches the event. The raw status is then read back and must still be 1. A second, isolated clear must bring it to 0, which shows that the clear itself works and that setting wins the tie.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned PINS_DEF = 8;

  // word index of the control registers inside the control window
  typedef enum logic [3:0] {
    CTL_DIR   = 4'd0,
    CTL_SENSE = 4'd1,
    CTL_BOTH  = 4'd2,
    CTL_POL   = 4'd3,
    CTL_IMASK = 4'd4,
    CTL_RAW   = 4'd5,
    CTL_MSTAT = 4'd6,
    CTL_CLEAR = 4'd7,
    CTL_ALT   = 4'd8,
    CTL_DEN   = 4'd9
  } ctl_reg_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = PINS + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_sync,
  input  logic [PINS-1:0]   irq_raw,
  input  logic [PINS-1:0]   irq_mstat,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   cfg_dir,
  output logic [PINS-1:0]   cfg_sense,
  output logic [PINS-1:0]   cfg_both,
  output logic [PINS-1:0]   cfg_pol,
  output logic [PINS-1:0]   cfg_imask,
  output logic [PINS-1:0]   cfg_alt,
  output logic [PINS-1:0]   cfg_den,
  output logic [PINS-1:0]   clr_pulse
);
  localparam int unsigned MASK_HI = PINS + 1;
  localparam int unsigned CTL_BIT = PINS + 2;
  localparam int unsigned TOP_BIT = PINS + 3;

  logic            data_acc, ctl_acc;
  logic [3:0]      idx;
  logic [PINS-1:0] amask;
  logic [PINS-1:0] pin_view;
  logic            unused_lsb;

  assign unused_lsb = ^bus_addr[1:0];
  assign data_acc   = bus_sel & ~bus_addr[TOP_BIT] & ~bus_addr[CTL_BIT];
  assign ctl_acc    = bus_sel & ~bus_addr[TOP_BIT] &  bus_addr[CTL_BIT];
  assign idx        = bus_addr[5:2];
  assign amask      = bus_addr[MASK_HI:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      cfg_dir   <= '0;
      cfg_sense <= '0;
      cfg_both  <= '0;
      cfg_pol   <= '0;
      cfg_imask <= '0;
      cfg_alt   <= '0;
      cfg_den   <= '0;
    end else begin
      if (data_acc && bus_wr)
        data_q <= (data_q & ~amask) | (bus_wdata & amask);
      if (ctl_acc && bus_wr) begin
        case (idx)
          CTL_DIR:   cfg_dir   <= bus_wdata;
          CTL_SENSE: cfg_sense <= bus_wdata;
          CTL_BOTH:  cfg_both  <= bus_wdata;
          CTL_POL:   cfg_pol   <= bus_wdata;
          CTL_IMASK: cfg_imask <= bus_wdata;
          CTL_ALT:   cfg_alt   <= bus_wdata;
          CTL_DEN:   cfg_den   <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end

  assign clr_pulse = (ctl_acc && bus_wr && idx == CTL_CLEAR) ? bus_wdata : '0;

  // output pins read back their driven value, inputs their synchronized level
  assign pin_view = cfg_den & ((cfg_dir & data_q) | (~cfg_dir & pin_sync));

  always_comb begin
    bus_rdata = '0;
    if (data_acc) begin
      bus_rdata = pin_view & amask;
    end else if (ctl_acc) begin
      case (idx)
        CTL_DIR:   bus_rdata = cfg_dir;
        CTL_SENSE: bus_rdata = cfg_sense;
        CTL_BOTH:  bus_rdata = cfg_both;
        CTL_POL:   bus_rdata = cfg_pol;
        CTL_IMASK: bus_rdata = cfg_imask;
        CTL_RAW:   bus_rdata = irq_raw;
        CTL_MSTAT: bus_rdata = irq_mstat;
        CTL_ALT:   bus_rdata = cfg_alt;
        CTL_DEN:   bus_rdata = cfg_den;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_sync,
  input  logic [PINS-1:0] cfg_sense,
  input  logic [PINS-1:0] cfg_both,
  input  logic [PINS-1:0] cfg_pol,
  input  logic [PINS-1:0] cfg_imask,
  input  logic [PINS-1:0] cfg_den,
  input  logic [PINS-1:0] clr_pulse,
  output logic [PINS-1:0] irq_raw,
  output logic [PINS-1:0] irq_mstat,
  output logic            irq
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] edge_q;
  logic [PINS-1:0] edge_d;
  logic [PINS-1:0] level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= pin_sync;
      edge_q <= edge_d;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic rise, fall, evt;
    assign rise = pin_sync[i] & ~prev_q[i];
    assign fall = ~pin_sync[i] & prev_q[i];
    assign evt  = cfg_den[i] & (cfg_both[i] ? (rise | fall)
                                            : (cfg_pol[i] ? rise : fall));
    // a new event outranks a clear arriving in the same cycle
    assign edge_d[i]    = ((edge_q[i] & ~clr_pulse[i]) | evt) & ~cfg_sense[i] & cfg_den[i];
    assign level_hit[i] = cfg_den[i] & ~(pin_sync[i] ^ cfg_pol[i]);
    assign irq_raw[i]   = cfg_sense[i] ? level_hit[i] : edge_q[i];
  end

  assign irq_mstat = irq_raw & cfg_imask;
  assign irq       = |irq_mstat;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned PINS = 8
) (
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] cfg_dir,
  input  logic [PINS-1:0] cfg_alt,
  input  logic [PINS-1:0] cfg_den,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  for (genvar i = 0; i < PINS; i++) begin : g_pad
    logic use_alt;
    assign use_alt    = cfg_alt[i] & cfg_den[i];
    assign pad_out[i] = use_alt ? alt_out[i] : data_q[i];
    assign pad_oe[i]  = use_alt ? alt_oe[i]  : cfg_dir[i];
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int unsigned PINS   = gpio_mask_pkg::PINS_DEF,
  parameter int unsigned ADDR_W = PINS + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic [PINS-1:0]   alt_out,
  input  logic [PINS-1:0]   alt_oe,
  output logic              irq
);
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] data_q, cfg_dir, cfg_sense, cfg_both, cfg_pol;
  logic [PINS-1:0] cfg_imask, cfg_alt, cfg_den, clr_pulse;
  logic [PINS-1:0] irq_raw, irq_mstat;

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_cfg_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(pin_sync), .irq_raw(irq_raw), .irq_mstat(irq_mstat),
    .data_q(data_q), .cfg_dir(cfg_dir), .cfg_sense(cfg_sense),
    .cfg_both(cfg_both), .cfg_pol(cfg_pol), .cfg_imask(cfg_imask),
    .cfg_alt(cfg_alt), .cfg_den(cfg_den), .clr_pulse(clr_pulse)
  );

  gpio_irq_detect #(.PINS(PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
    .cfg_sense(cfg_sense), .cfg_both(cfg_both), .cfg_pol(cfg_pol),
    .cfg_imask(cfg_imask), .cfg_den(cfg_den), .clr_pulse(clr_pulse),
    .irq_raw(irq_raw), .irq_mstat(irq_mstat), .irq(irq)
  );

  gpio_pad_mux #(.PINS(PINS)) u_pad (
    .data_q(data_q), .cfg_dir(cfg_dir), .cfg_alt(cfg_alt), .cfg_den(cfg_den),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = PINS + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   alt_oe,
  input logic              irq,
  input logic [PINS-1:0]   data_q,
  input logic [PINS-1:0]   cfg_alt,
  input logic [PINS-1:0]   cfg_den,
  input logic [PINS-1:0]   cfg_sense,
  input logic [PINS-1:0]   cfg_imask,
  input logic [PINS-1:0]   irq_raw,
  input logic [PINS-1:0]   clr_pulse
);
  localparam int unsigned MASK_HI = PINS + 1;
  localparam int unsigned CTL_BIT = PINS + 2;
  localparam int unsigned TOP_BIT = PINS + 3;

  logic data_win;
  assign data_win = bus_sel && !bus_addr[TOP_BIT] && !bus_addr[CTL_BIT];

  p_rd_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_win && !bus_wr) |-> ((bus_rdata & ~bus_addr[MASK_HI:2]) == '0));

  p_wr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_win && bus_wr) |=>
      (data_q == (($past(data_q) & ~$past(bus_addr[MASK_HI:2])) |
                  ($past(bus_wdata) & $past(bus_addr[MASK_HI:2])))));

  p_alt_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ alt_oe) & cfg_alt & cfg_den) == '0));

  p_den_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_den == '0) |-> !irq);

  p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_raw) & ~$past(clr_pulse) & ~$past(cfg_sense) &
               $past(cfg_den) & ~cfg_sense & cfg_den & ~irq_raw) == '0));

  p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_imask == '0) |-> !irq);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_oe(pad_oe), .alt_oe(alt_oe), .irq(irq), .data_q(data_q),
  .cfg_alt(cfg_alt), .cfg_den(cfg_den), .cfg_sense(cfg_sense),
  .cfg_imask(cfg_imask), .irq_raw(irq_raw), .clr_pulse(clr_pulse)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  localparam int unsigned PINS = 8;
  localparam int unsigned AW   = 12;
  localparam logic [AW-1:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
    A_POL = 12'h40C, A_IMASK = 12'h410, A_RAW = 12'h414, A_MSTAT = 12'h418,
    A_CLR = 12'h41C, A_ALT = 12'h420, A_DEN = 12'h424, A_ALL = 12'h3FC;

  // op: 0 write, 1 read-compare, 2 pad compare {oe,out}
  localparam int NV = 16;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 12'h424, 16'h00FF},
    {2'd0, 12'h400, 16'h000F},
    {2'd0, 12'h3FC, 16'h00A5},
    {2'd1, 12'h3FC, 16'h0035},
    {2'd2, 12'h000, 16'h0FA5},
    {2'd0, 12'h00C, 16'h00FE},
    {2'd1, 12'h3FC, 16'h0036},
    {2'd2, 12'h000, 16'h0FA6},
    {2'd1, 12'h004, 16'h0000},
    {2'd1, 12'h018, 16'h0006},
    {2'd1, 12'h3C0, 16'h0030},
    {2'd1, 12'h400, 16'h000F},
    {2'd1, 12'h424, 16'h00FF},
    {2'd1, 12'h41C, 16'h0000},
    {2'd0, 12'h800, 16'h00FF},
    {2'd1, 12'h3FC, 16'h0036}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0, bus_rdata;
  logic [PINS-1:0] pad_in = '0, pad_out, pad_oe;
  logic [PINS-1:0] alt_out = '0, alt_oe = '0;
  logic            irq;
  int              n_chk = 0, n_err = 0;
  bit              done = 1'b0;

  always #2 clk = ~clk;

  gpio_mask_port #(.PINS(PINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [PINS-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [PINS-1:0] e);
    logic [PINS-1:0] v;
    rd(a, v);
    check(req, {8'h00, v}, {8'h00, e});
  endtask

  task automatic pin(input logic [PINS-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    pad_in = 8'h30;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", {8'h00, pad_oe}, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;
    rd_chk("R1 den", A_DEN, 8'h00);
    rd_chk("R1 alt", A_ALT, 8'h00);
    rd_chk("R1 dir", A_DIR, 8'h00);
    rd_chk("R1 data", A_ALL, 8'h00);

    // vector walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [1:0]      op;
      logic [AW-1:0]   a;
      logic [15:0]     d;
      {op, a, d} = VEC[i];
      case (op)
        2'd0: wr(a, d[7:0]);
        2'd1: rd_chk("R2/R3/R4 vector read", a, d[7:0]);
        default: begin
          @(negedge clk);
          check("R4/R5 vector pad", {pad_oe, pad_out}, d);
        end
      endcase
    end

    // interrupt configuration: bit0 rise, bit1 fall, bit2 both, bit4 high level
    wr(A_DIR, 8'h00);
    pin(8'h00);
    wr(A_SENSE, 8'h10); wr(A_BOTH, 8'h04); wr(A_POL, 8'h11); wr(A_IMASK, 8'h17);
    repeat (4) @(negedge clk);
    wr(A_CLR, 8'hFF);
    rd_chk("R7 cleared", A_RAW, 8'h00);
    check("R10 idle irq", {15'd0, irq}, 16'h0000);
    pin(8'h01);
    rd_chk("R9 rising", A_RAW, 8'h01);
    rd_chk("R10 mstat", A_MSTAT, 8'h01);
    check("R10 irq", {15'd0, irq}, 16'h0001);
    pin(8'h03);
    rd_chk("R9 rise ignored on falling pin", A_RAW, 8'h01);
    pin(8'h01);
    rd_chk("R9 falling", A_RAW, 8'h03);
    pin(8'h05);
    rd_chk("R9 both rise", A_RAW, 8'h07);
    pin(8'h01);
    rd_chk("R7 sticky", A_RAW, 8'h07);
    wr(A_CLR, 8'h04);
    rd_chk("R7 clear one bit", A_RAW, 8'h03);
    pin(8'h11);
    rd_chk("R8 level high", A_RAW, 8'h13);
    wr(A_CLR, 8'h10);
    rd_chk("R8 clear no effect", A_RAW, 8'h13);
    pin(8'h01);
    rd_chk("R8 level follows", A_RAW, 8'h03);
    wr(A_IMASK, 8'h10);
    rd_chk("R10 masked off", A_MSTAT, 8'h00);
    check("R10 irq masked", {15'd0, irq}, 16'h0000);
    pin(8'h11);
    check("R10 irq level", {15'd0, irq}, 16'h0001);
    pin(8'h01);
    wr(A_CLR, 8'h0F);
    rd_chk("R7 clear all", A_RAW, 8'h00);

    // R7 collision: clear sampled at the same edge that latches a new rise
    wr(A_IMASK, 8'h17);
    pin(8'h00);
    wr(A_CLR, 8'hFF);
    @(negedge clk); pad_in = 8'h01;
    @(negedge clk);
    wr(A_CLR, 8'h01);
    rd_chk("R7 set wins over clear", A_RAW, 8'h01);
    wr(A_CLR, 8'h01);
    rd_chk("R7 clear after collision", A_RAW, 8'h00);

    // R6 digital enable gating
    wr(A_DEN, 8'hEE);
    pin(8'h00);
    pin(8'h11);
    rd_chk("R6 raw gated", A_RAW, 8'h00);
    rd_chk("R6 data read gated", 12'h004, 8'h00);
    check("R6 irq", {15'd0, irq}, 16'h0000);

    // R5 alternate routing
    wr(A_DEN, 8'hFF);
    alt_out = 8'h00; alt_oe = 8'h80;
    wr(A_ALT, 8'h80);
    check("R5 alt oe", {8'h00, pad_oe}, 16'h0080);
    check("R5 alt out", {15'd0, pad_out[7]}, 16'h0000);
    wr(A_DEN, 8'h7F);
    check("R5 gpio oe", {8'h00, pad_oe}, 16'h0000);
    check("R5 gpio out", {15'd0, pad_out[7]}, 16'h0001);

    // R11 back-to-back writes
    wr(A_DIR, 8'h01);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = 8'h01;
    @(negedge clk);
    check("R11 toggle 1", {15'd0, pad_out[0]}, 16'h0001);
    bus_wdata = 8'h00;
    @(negedge clk);
    check("R11 toggle 0", {15'd0, pad_out[0]}, 16'h0000);
    bus_wdata = 8'h01;
    @(negedge clk);
    check("R11 toggle 1 again", {15'd0, pad_out[0]}, 16'h0001);
    bus_sel = 1'b0; bus_wr = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule